// File: doc/BRIEF.md
# Short-Frame Serial Audio Slave Port

This block is the codec-side end of a synchronous serial audio link in which an external master drives both the bit clock and the frame sync. Each frame carries one 16-bit sample in each direction. The sample arriving on the serial input is assembled into a parallel receive word. A parallel transmit word is shifted out on the serial output. Bits travel most significant first.

Two frame layouts are available. The long layout spans 32 bit clocks and has two 16-clock channel slots, with the sample in the second slot. The short layout spans 17 bit clocks: the first channel slot shrinks to a single clock that carries nothing, and the second slot keeps all 16 data clocks. The short layout only makes sense here because the master owns the clocks.

The bit clock, frame sync and serial input are brought into the system clock domain through a synchronizer chain and then edge-detected. The parallel sides are valid/ready streams. The receive stream holds its word until the consumer accepts it. The port cannot stall the link, so a word that completes while the previous one is still held is discarded and flagged. On the transmit side, ready is offered for exactly one system cycle per frame, at the start of the data slot. A word is taken when valid is high in that cycle. If valid is low, the slot is filled with zeros and flagged.

Top module: `aif_slave_port`

## Requirements
- R1: The serial output changes only in the system cycle that follows a detected rising edge of the bit clock.
- R2: The serial input is captured only on detected falling edges of the bit clock, so a bit held stable around the falling edge is received correctly.
- R3: A frame begins at the first falling edge of the bit clock that sees frame sync high after it was low at the previous falling edge. That bit clock is clock 0 of the frame.
- R4: With `short_mode` = 0 the frame spans 32 bit clocks. Data occupies clocks 16 to 31. Serial input during clocks 0 to 15 is ignored, and the serial output is low there.
- R5: With `short_mode` = 1 the frame spans 17 bit clocks. Clock 0 carries no data and the serial output is low there. Data occupies clocks 1 to 16. Back-to-back 17-clock frames raise no error.
- R6: Both directions send bit 15 first and bit 0 last.
- R7: A received word is presented with `rx_valid` high and stays valid and unchanged until `rx_ready` is high. `rx_valid` falls in the cycle after acceptance unless a new word arrives in that cycle.
- R8: `tx_ready` is high for exactly one system cycle per frame, at the rise that opens the data slot. With `tx_valid` high in that cycle, `tx_data` is taken and sent in that frame.
- R9: If `tx_valid` is low when `tx_ready` is offered, the frame's data slot is sent as zeros and `tx_underrun` pulses for one cycle.
- R10: If a word completes while the previous one is still held unaccepted, the new word is discarded, the held word stays, and `rx_overrun` pulses for one cycle.
- R11: A new frame start that comes before the current layout's frame length has elapsed pulses `frame_err`. The partial receive word is discarded and counting restarts from clock 0.
- R12: `short_mode` is sampled only at a frame start. A change in the middle of a frame does not alter that frame's layout.
- R13: After reset and before the first frame start, the serial output stays low, `tx_ready` stays low and no receive word is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Bit clock from the external master |
| fsync | input | 1 | Frame sync from the external master |
| sdi | input | 1 | Serial data into the port |
| sdo | output | 1 | Serial data out of the port |
| short_mode | input | 1 | 1 selects the 17-clock frame, 0 the 32-clock frame |
| tx_data | input | 16 | Transmit word |
| tx_valid | input | 1 | Transmit word present |
| tx_ready | output | 1 | One-cycle offer to take the transmit word |
| rx_data | output | 16 | Received word |
| rx_valid | output | 1 | Received word held and waiting |
| rx_ready | input | 1 | Consumer accepts the received word |
| tx_underrun | output | 1 | Pulse: no transmit word was available for the slot |
| rx_overrun | output | 1 | Pulse: a received word was discarded |
| frame_err | output | 1 | Pulse: frame sync arrived early |

## Verification
The embedded properties check the following on every cycle:
- the serial output moves only after a rising edge and the receive shifter only after a falling edge;
- the receive word is held under back-pressure, including across an overrun;
- the transmit offer lasts one cycle;
- no transmit offer occurs before the first frame;
- the layout selection changes only at a frame start.

Only the directed scenarios can show that whole words land in the right slot in the right bit order. They also show that channel 1 input is ignored and that the 17-clock layout keeps its full 16 data clocks. The remaining scenario checks are that an early frame sync discards its partial word, that an overrun discards the newer word, and that a mid-frame mode change leaves the current frame alone.

// File: rtl/aif_pkg.sv
package aif_pkg;
  typedef enum logic {
    FRAME_LONG  = 1'b0,
    FRAME_SHORT = 1'b1
  } frame_mode_e;
endpackage

// File: rtl/aif_sync.sv
module aif_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/aif_frame_timer.sv
module aif_frame_timer
  import aif_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int LONG_CLKS = 32,
  parameter int CNT_W     = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_s,
  input  logic fs_s,
  input  logic short_mode,
  output logic bit_rise,
  output logic bit_fall,
  output logic framed,
  output logic rx_shift_en,
  output logic rx_last,
  output logic tx_load,
  output logic tx_shift_en,
  output logic frame_err
);
  localparam logic [CNT_W-1:0] L_FIRST = CNT_W'(LONG_CLKS - SAMPLE_W);
  localparam logic [CNT_W-1:0] S_FIRST = CNT_W'(1);
  localparam logic [CNT_W-1:0] L_LEN   = CNT_W'(LONG_CLKS);
  localparam logic [CNT_W-1:0] S_LEN   = CNT_W'(SAMPLE_W + 1);
  localparam logic [CNT_W-1:0] SPAN    = CNT_W'(SAMPLE_W - 1);
  localparam logic [CNT_W-1:0] CMAX    = '1;

  logic              bclk_d, fs_prev;
  logic [CNT_W-1:0]  cnt, cnt_inc, fall_idx, first, last, flen;
  frame_mode_e       mode_q;
  logic              frame_start;

  assign bit_rise    = bclk_s & ~bclk_d;
  assign bit_fall    = ~bclk_s & bclk_d;
  assign frame_start = bit_fall & fs_s & ~fs_prev;

  assign cnt_inc  = (cnt == CMAX) ? cnt : cnt + CNT_W'(1);
  assign fall_idx = frame_start ? '0 : cnt_inc;

  assign first = (mode_q == FRAME_SHORT) ? S_FIRST : L_FIRST;
  assign flen  = (mode_q == FRAME_SHORT) ? S_LEN : L_LEN;
  assign last  = first + SPAN;

  assign rx_shift_en = bit_fall & framed & ~frame_start &
                       (fall_idx >= first) & (fall_idx <= last);
  assign rx_last     = rx_shift_en & (fall_idx == last);
  assign tx_load     = bit_rise & framed & (cnt_inc == first);
  assign tx_shift_en = bit_rise & framed & (cnt_inc > first) & (cnt_inc <= last);
  assign frame_err   = frame_start & framed & (cnt_inc < flen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_d  <= 1'b0;
      fs_prev <= 1'b1;
      cnt     <= CMAX;
      framed  <= 1'b0;
      mode_q  <= FRAME_LONG;
    end else begin
      bclk_d <= bclk_s;
      if (bit_fall) begin
        fs_prev <= fs_s;
        cnt     <= fall_idx;
        if (frame_start) begin
          framed <= 1'b1;
          mode_q <= frame_mode_e'(short_mode);
        end
      end
    end
  end

  // R11
  early_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> (cnt == '0) && framed);

  // R12
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(mode_q));
endmodule

// File: rtl/aif_tx_path.sv
module aif_tx_path #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_rise,
  input  logic                framed,
  input  logic                tx_load,
  input  logic                tx_shift_en,
  input  logic [SAMPLE_W-1:0] tx_data,
  input  logic                tx_valid,
  output logic                tx_ready,
  output logic                sdo,
  output logic                tx_underrun
);
  logic [SAMPLE_W-1:0] sh;

  assign tx_ready = tx_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh          <= '0;
      sdo         <= 1'b0;
      tx_underrun <= 1'b0;
    end else begin
      tx_underrun <= tx_load & ~tx_valid;
      if (tx_load) begin
        if (tx_valid) begin
          sdo <= tx_data[SAMPLE_W-1];
          sh  <= tx_data << 1;
        end else begin
          sdo <= 1'b0;
          sh  <= '0;
        end
      end else if (tx_shift_en) begin
        sdo <= sh[SAMPLE_W-1];
        sh  <= sh << 1;
      end else if (bit_rise) begin
        sdo <= 1'b0;
      end
    end
  end

  // R1
  sdo_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> $past(bit_rise));

  // R8
  ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> !tx_ready);

  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !framed |-> !tx_ready && !sdo);

  // R9
  underrun_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underrun |-> !sdo);
endmodule

// File: rtl/aif_rx_path.sv
module aif_rx_path #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_fall,
  input  logic                rx_shift_en,
  input  logic                rx_last,
  input  logic                sdi_s,
  input  logic                rx_ready,
  output logic [SAMPLE_W-1:0] rx_data,
  output logic                rx_valid,
  output logic                rx_overrun
);
  logic [SAMPLE_W-1:0] sh, word_nxt;

  assign word_nxt = {sh[SAMPLE_W-2:0], sdi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh         <= '0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      rx_overrun <= 1'b0;
    end else begin
      if (rx_shift_en) sh <= word_nxt;
      rx_overrun <= rx_last & rx_valid & ~rx_ready;
      if (rx_last && (!rx_valid || rx_ready)) begin
        rx_data  <= word_nxt;
        rx_valid <= 1'b1;
      end else if (rx_valid && rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end

  // R2
  shift_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sh) |-> $past(bit_fall));

  // R7
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));

  // R10
  overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |-> rx_valid && $stable(rx_data));
endmodule

// File: rtl/aif_slave_port.sv
module aif_slave_port #(
  parameter int SAMPLE_W    = 16,
  parameter int LONG_CLKS   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk,
  input  logic                fsync,
  input  logic                sdi,
  output logic                sdo,
  input  logic                short_mode,
  input  logic [SAMPLE_W-1:0] tx_data,
  input  logic                tx_valid,
  output logic                tx_ready,
  output logic [SAMPLE_W-1:0] rx_data,
  output logic                rx_valid,
  input  logic                rx_ready,
  output logic                tx_underrun,
  output logic                rx_overrun,
  output logic                frame_err
);
  localparam int CNT_W = $clog2(LONG_CLKS) + 1;

  logic [2:0] pins_s;
  logic bit_rise, bit_fall, framed;
  logic rx_shift_en, rx_last, tx_load, tx_shift_en;

  aif_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b000)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({bclk, fsync, sdi}), .q(pins_s)
  );

  aif_frame_timer #(.SAMPLE_W(SAMPLE_W), .LONG_CLKS(LONG_CLKS), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .bclk_s(pins_s[2]), .fs_s(pins_s[1]), .short_mode(short_mode),
    .bit_rise(bit_rise), .bit_fall(bit_fall), .framed(framed),
    .rx_shift_en(rx_shift_en), .rx_last(rx_last),
    .tx_load(tx_load), .tx_shift_en(tx_shift_en),
    .frame_err(frame_err)
  );

  aif_tx_path #(.SAMPLE_W(SAMPLE_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .bit_rise(bit_rise), .framed(framed),
    .tx_load(tx_load), .tx_shift_en(tx_shift_en),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .sdo(sdo), .tx_underrun(tx_underrun)
  );

  aif_rx_path #(.SAMPLE_W(SAMPLE_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .bit_fall(bit_fall), .rx_shift_en(rx_shift_en), .rx_last(rx_last),
    .sdi_s(pins_s[0]), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_overrun(rx_overrun)
  );
endmodule

// File: tb/aif_slave_port_bench.sv
`timescale 1ns/1ps
module aif_slave_port_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bclk = 1'b0, fsync = 1'b0, sdi = 1'b0, short_mode = 1'b0;
  logic [15:0] tx_data = '0;
  logic tx_valid = 1'b0, rx_ready = 1'b0;
  logic sdo, tx_ready, rx_valid, tx_underrun, rx_overrun, frame_err;
  logic [15:0] rx_data;

  int total = 0, bad = 0;
  int takes = 0, unders = 0, overs = 0, ferrs = 0;

  always #4 clk = ~clk;

  aif_slave_port u_aif_slave_port (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .sdi(sdi), .sdo(sdo),
    .short_mode(short_mode), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .tx_underrun(tx_underrun), .rx_overrun(rx_overrun),
    .frame_err(frame_err)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      if (tx_valid && tx_ready) takes++;
      if (tx_underrun) unders++;
      if (rx_overrun) overs++;
      if (frame_err) ferrs++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one master bit clock; fs and data change after the rise, sdo read before the fall
  task automatic do_frame(input bit sh_exp, input logic [15:0] word_in, input int nclk,
                          input int flip_at, output logic [15:0] got, output int ch1_hi);
    int slot;
    slot = sh_exp ? 1 : 16;
    got = '0;
    ch1_hi = 0;
    for (int i = 0; i < nclk; i++) begin
      @(negedge clk) bclk = 1'b1;
      repeat (2) @(negedge clk);
      fsync = (i == 0);
      sdi = (i >= slot && i < slot + 16) ? word_in[15 - (i - slot)] : 1'b1;
      if (i == flip_at) short_mode = ~short_mode;
      repeat (6) @(negedge clk);
      if (i >= slot && i < slot + 16) got[15 - (i - slot)] = sdo;
      else if (sdo) ch1_hi++;
      bclk = 1'b0;
      repeat (8) @(negedge clk);
    end
  endtask

  task automatic accept_rx();
    @(negedge clk) rx_ready = 1'b1;
    @(negedge clk) rx_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    int hi;
    chk(sdo == 1'b0 && rx_valid == 1'b0 && tx_ready == 1'b0, "R13 reset outputs", {sdo, rx_valid, tx_ready}, 0);
    hi = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk) bclk = 1'b1;
      sdi = 1'b1;
      repeat (8) @(negedge clk);
      if (sdo) hi++;
      bclk = 1'b0;
      repeat (8) @(negedge clk);
    end
    chk(hi == 0 && takes == 0 && rx_valid == 1'b0, "R13 idle before first frame", hi + takes, 0);
  endtask

  task automatic t_normal(input logic [15:0] win, input logic [15:0] wout);
    logic [15:0] got;
    int hi, t0, e0;
    t0 = takes; e0 = ferrs;
    tx_data = wout; tx_valid = 1'b1;
    do_frame(1'b0, win, 32, -1, got, hi);
    chk(got == wout, "R1 R6 R4 sdo word in slot 2", got, wout);
    chk(hi == 0, "R4 sdo low in channel 1", hi, 0);
    chk(rx_valid && rx_data == win, "R2 R6 R4 rx word", rx_data, win);
    chk(takes - t0 == 1, "R8 one transmit take", takes - t0, 1);
    chk(ferrs == e0, "R3 no frame error on 32-clock frame", ferrs - e0, 0);
    accept_rx();
    chk(rx_valid == 1'b0, "R7 valid drops after accept", rx_valid, 0);
  endtask

  task automatic t_short(input logic [15:0] win, input logic [15:0] wout);
    logic [15:0] got;
    int hi, e0;
    e0 = ferrs;
    short_mode = 1'b1;
    tx_data = wout; tx_valid = 1'b1;
    do_frame(1'b1, win, 17, -1, got, hi);
    chk(got == wout && hi == 0, "R5 short frame sdo", got, wout);
    chk(rx_valid && rx_data == win, "R5 short frame rx", rx_data, win);
    chk(ferrs == e0, "R5 no error on 17-clock frame", ferrs - e0, 0);
    accept_rx();
  endtask

  task automatic t_underrun();
    logic [15:0] got;
    int hi, u0, t0;
    u0 = unders; t0 = takes;
    short_mode = 1'b0;
    tx_valid = 1'b0; tx_data = 16'hFFFF;
    do_frame(1'b0, 16'h5555, 32, -1, got, hi);
    chk(got == 16'h0000, "R9 zeros sent on underrun", got, 0);
    chk(unders - u0 == 1 && takes == t0, "R9 underrun pulse", unders - u0, 1);
    accept_rx();
    tx_valid = 1'b1;
  endtask

  task automatic t_overrun();
    logic [15:0] got;
    int hi, o0;
    o0 = overs;
    tx_data = 16'h0F0F;
    do_frame(1'b0, 16'h1111, 32, -1, got, hi);
    do_frame(1'b0, 16'h2222, 32, -1, got, hi);
    chk(rx_valid && rx_data == 16'h1111, "R10 held word kept", rx_data, 16'h1111);
    chk(overs - o0 == 1, "R10 overrun pulse", overs - o0, 1);
    accept_rx();
    chk(rx_valid == 1'b0, "R10 R7 newer word dropped", rx_valid, 0);
  endtask

  task automatic t_early();
    logic [15:0] got;
    int hi, e0;
    e0 = ferrs;
    do_frame(1'b0, 16'hDEAD, 20, -1, got, hi);
    do_frame(1'b0, 16'hBEEF, 32, -1, got, hi);
    chk(ferrs - e0 == 1, "R11 early frame error", ferrs - e0, 1);
    chk(rx_valid && rx_data == 16'hBEEF, "R11 partial dropped, restart ok", rx_data, 16'hBEEF);
    accept_rx();
    chk(rx_valid == 1'b0, "R11 only one word delivered", rx_valid, 0);
  endtask

  task automatic t_mode_mid();
    logic [15:0] got;
    int hi, e0;
    e0 = ferrs;
    short_mode = 1'b0;
    tx_data = 16'hC3A5;
    do_frame(1'b0, 16'h0F0F, 32, 5, got, hi);
    chk(got == 16'hC3A5 && hi == 0, "R12 layout kept after mid-frame change", got, 16'hC3A5);
    chk(rx_valid && rx_data == 16'h0F0F, "R12 rx in long slot", rx_data, 16'h0F0F);
    accept_rx();
    short_mode = 1'b0;
    do_frame(1'b0, 16'h7E81, 32, -1, got, hi);
    chk(rx_data == 16'h7E81 && ferrs == e0, "R12 next frame normal", rx_data, 16'h7E81);
    accept_rx();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_normal(16'hA5C3, 16'h3C5A);
    t_normal(16'h8001, 16'h7FFE);
    t_short(16'h1234, 16'hF00F);
    t_short(16'hFFFE, 16'h0001);
    t_underrun();
    t_overrun();
    t_early();
    t_mode_mid();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule